// File: doc/BRIEF.md
# Two-Key Write Unlock Controller

This block keeps two non-volatile memory regions write-protected until software proves intent. Each region, the main program area and the data/option area, has its own key register on a small byte-wide register bus. Only two writes of the correct key bytes, in the correct order, open the region. The open state drives a write-enable line toward the flash sequencer. Software closes a region again by writing a zero to that region's bit in the shared status register.

The two regions answer a bad key in opposite ways. In the program area, a wrong key causes a lockout that only a reset removes. The data area simply drops back and accepts a new attempt at once. Writes to the option block also need an option-enable bit in the control register, on top of an open data area.

Top module: `key_unlock_ctrl`

## Requirements
- R1: After reset, both regions are locked. prog_we_o, data_we_o and opt_we_o are 0, and the status and control registers read as 0x00.
- R2: Writing 0x56 and then 0xAE to the program key register (offset 2) sets prog_we_o and status bit 1 from the cycle after the second write.
- R3: Writing 0xAE and then 0x56 to the data key register (offset 3) sets data_we_o and status bit 3 from the cycle after the second write.
- R4: Any other byte written to the program key register while that region is locked closes the program area until reset. Later key writes to it are ignored, including a correct pair, so 0xAE followed by 0x56 never opens it.
- R5: A wrong byte written to the data key register does not block that region. A correct pair written right after opens it. If the byte in the second-key position is 0xAE, it starts a fresh sequence.
- R6: Writing the status register (offset 4) with bit 1 at 0 re-locks the program area, and with bit 3 at 0 re-locks the data area. Writing 1 to either bit never unlocks a region.
- R7: opt_we_o is 1 only while the data area is open and bit 7 of the control register (offset 1, read back at bit 7) is 1.
- R8: Key writes to a region that is already open leave it open and do not cause a lockout.
- R9: A reset clears a program-area lockout, and the correct pair then opens the region.
- R10: Writes to one region's key register do not change the other region's state or sequence progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| prog_we_o | output | 1 | Program area write enable |
| data_we_o | output | 1 | Data area write enable |
| opt_we_o | output | 1 | Option block write enable |

## Verification
Every output is a direct decode of a registered sequence state, so a wrong state shows at the write enables and the status readback on the very cycle after the write that caused it. The bench keeps its own model of each region's progress and compares all four observable values after each bus cycle. A missed lockout shows up only on a later correct pair, so the bench follows each wrong program key with a correct pair. In the same way it follows each data miss with a retry, so a wrong recovery rule also becomes visible.

// File: rtl/key_unlock_pkg.sv
package key_unlock_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned PROG_BIT = 1;
  localparam int unsigned DATA_BIT = 3;
  localparam int unsigned OPT_BIT  = 7;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_HALF  = 2'd1,
    KS_OPEN  = 2'd2,
    KS_BLOCK = 2'd3
  } key_state_e;
endpackage

// File: rtl/key_bus_decode.sv
module key_bus_decode #(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADR = 1,
  parameter logic [ADDR_W-1:0] PKEY_ADR = 2,
  parameter logic [ADDR_W-1:0] DKEY_ADR = 3,
  parameter logic [ADDR_W-1:0] STAT_ADR = 4
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ctrl_wr_o,
  output logic              pkey_wr_o,
  output logic              dkey_wr_o,
  output logic              stat_wr_o
);
  assign ctrl_wr_o = we_i && (addr_i == CTRL_ADR);
  assign pkey_wr_o = we_i && (addr_i == PKEY_ADR);
  assign dkey_wr_o = we_i && (addr_i == DKEY_ADR);
  assign stat_wr_o = we_i && (addr_i == STAT_ADR);
endmodule

// File: rtl/key_seq.sv
module key_seq
  import key_unlock_pkg::*;
#(
  parameter logic [DATA_W-1:0] FIRST_KEY  = 8'h56,
  parameter logic [DATA_W-1:0] SECOND_KEY = 8'hAE,
  parameter bit                STICKY     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic              relock_i,
  output logic              open_o,
  output logic              blocked_o
);
  key_state_e state_q, state_d;
  key_state_e miss_state;

  // wrong key: lockout or restart, chosen per region
  if (STICKY) begin : g_sticky
    assign miss_state = KS_BLOCK;
  end else begin : g_retry
    assign miss_state = KS_IDLE;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_IDLE: if (key_wr_i) state_d = (key_i == FIRST_KEY) ? KS_HALF : miss_state;
      KS_HALF: if (key_wr_i) begin
        if (key_i == SECOND_KEY)                state_d = KS_OPEN;
        else if (!STICKY && key_i == FIRST_KEY) state_d = KS_HALF;
        else                                    state_d = miss_state;
      end
      KS_OPEN:  if (relock_i) state_d = KS_IDLE;
      KS_BLOCK: state_d = KS_BLOCK;
      default:  state_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_IDLE;
    else         state_q <= state_d;
  end

  assign open_o    = (state_q == KS_OPEN);
  assign blocked_o = (state_q == KS_BLOCK);
endmodule

// File: rtl/key_unlock_ctrl.sv
module key_unlock_ctrl
  import key_unlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADR = 1,
  parameter logic [ADDR_W-1:0] PKEY_ADR = 2,
  parameter logic [ADDR_W-1:0] DKEY_ADR = 3,
  parameter logic [ADDR_W-1:0] STAT_ADR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              prog_we_o,
  output logic              data_we_o,
  output logic              opt_we_o
);
  logic ctrl_wr, pkey_wr, dkey_wr, stat_wr;
  logic prog_open, data_open, prog_blocked, data_blocked;
  logic opt_en_q;

  key_bus_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADR(CTRL_ADR), .PKEY_ADR(PKEY_ADR),
    .DKEY_ADR(DKEY_ADR), .STAT_ADR(STAT_ADR)
  ) u_dec (
    .we_i(bus_we_i), .addr_i(bus_addr_i),
    .ctrl_wr_o(ctrl_wr), .pkey_wr_o(pkey_wr),
    .dkey_wr_o(dkey_wr), .stat_wr_o(stat_wr)
  );

  key_seq #(.FIRST_KEY(8'h56), .SECOND_KEY(8'hAE), .STICKY(1'b1)) u_prog (
    .clk_i, .rst_ni, .key_wr_i(pkey_wr), .key_i(bus_wdata_i),
    .relock_i(stat_wr && !bus_wdata_i[PROG_BIT]),
    .open_o(prog_open), .blocked_o(prog_blocked)
  );

  key_seq #(.FIRST_KEY(8'hAE), .SECOND_KEY(8'h56), .STICKY(1'b0)) u_data (
    .clk_i, .rst_ni, .key_wr_i(dkey_wr), .key_i(bus_wdata_i),
    .relock_i(stat_wr && !bus_wdata_i[DATA_BIT]),
    .open_o(data_open), .blocked_o(data_blocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      opt_en_q <= 1'b0;
    else if (ctrl_wr) opt_en_q <= bus_wdata_i[OPT_BIT];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == STAT_ADR) begin
      bus_rdata_o[PROG_BIT] = prog_open;
      bus_rdata_o[DATA_BIT] = data_open;
    end else if (bus_addr_i == CTRL_ADR) begin
      bus_rdata_o[OPT_BIT] = opt_en_q;
    end
  end

  assign prog_we_o = prog_open;
  assign data_we_o = data_open && !data_blocked;
  assign opt_we_o  = data_open && opt_en_q;
endmodule

// File: rtl/key_unlock_chk.sv
module key_unlock_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADR = 1,
  parameter logic [ADDR_W-1:0] PKEY_ADR = 2,
  parameter logic [ADDR_W-1:0] DKEY_ADR = 3,
  parameter logic [ADDR_W-1:0] STAT_ADR = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [7:0]        bus_wdata_i,
  input logic              prog_we_o,
  input logic              data_we_o,
  input logic              opt_we_o,
  input logic              prog_blocked
);
  logic prog_clr, data_clr;
  assign prog_clr = bus_we_i && bus_addr_i == STAT_ADR && !bus_wdata_i[1];
  assign data_clr = bus_we_i && bus_addr_i == STAT_ADR && !bus_wdata_i[3];

  a_r2_prog_opens_on_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_we_o) |-> $past(bus_we_i && bus_addr_i == PKEY_ADR && bus_wdata_i == 8'hAE));

  a_r3_data_opens_on_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_we_o) |-> $past(bus_we_i && bus_addr_i == DKEY_ADR && bus_wdata_i == 8'h56));

  a_r4_lockout_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_blocked |=> prog_blocked && !prog_we_o);

  a_r6_prog_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_we_o && prog_clr |=> !prog_we_o);

  a_r6_data_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o && data_clr |=> !data_we_o);

  a_r7_opt_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(opt_we_o) |-> $past((bus_we_i && bus_addr_i == CTRL_ADR && bus_wdata_i[7]) ||
                              (bus_we_i && bus_addr_i == DKEY_ADR)));

  a_r8_prog_stays_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_we_o && !prog_clr |=> prog_we_o);

  a_r8_data_stays_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o && !data_clr |=> data_we_o);
endmodule

bind key_unlock_ctrl key_unlock_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADR(CTRL_ADR), .PKEY_ADR(PKEY_ADR),
  .DKEY_ADR(DKEY_ADR), .STAT_ADR(STAT_ADR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .prog_we_o(prog_we_o), .data_we_o(data_we_o),
  .opt_we_o(opt_we_o), .prog_blocked(prog_blocked)
);

// File: tb/test_key_unlock_ctrl.sv
`timescale 1ns/1ps
module test_key_unlock_ctrl;
  localparam int AW = 4;
  localparam logic [AW-1:0] CA = 1, PK = 2, DK = 3, SA = 4;

  logic clk = 1'b0, rst_ni = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic prog_we, data_we, opt_we;
  int total = 0, bad = 0;
  // model: 0 idle, 1 first key seen, 2 open, 3 locked out
  int pst = 0, dst = 0;
  bit opt = 0;

  always #10 clk = ~clk;

  key_unlock_ctrl #(.ADDR_W(AW)) i_key_unlock_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .prog_we_o(prog_we), .data_we_o(data_we), .opt_we_o(opt_we)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [7:0] st;
    we = 1'b0; addr = SA; #1;
    st = 8'h00;
    st[1] = (pst == 2);
    st[3] = (dst == 2);
    chk({tag, " prog_we"}, {7'd0, prog_we}, {7'd0, pst == 2});
    chk({tag, " data_we"}, {7'd0, data_we}, {7'd0, dst == 2});
    chk({tag, " opt_we"},  {7'd0, opt_we},  {7'd0, dst == 2 && opt});
    chk({tag, " status"},  rdata, st);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, string tag);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    if (a == PK) begin
      if (pst == 0)      pst = (d == 8'h56) ? 1 : 3;
      else if (pst == 1) pst = (d == 8'hAE) ? 2 : 3;
    end else if (a == DK) begin
      if (dst == 0)      dst = (d == 8'hAE) ? 1 : 0;
      else if (dst == 1) dst = (d == 8'h56) ? 2 : ((d == 8'hAE) ? 1 : 0);
    end else if (a == SA) begin
      if (!d[1] && pst == 2) pst = 0;
      if (!d[3] && dst == 2) dst = 0;
    end else if (a == CA) begin
      opt = d[7];
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_ni = 1'b0; we = 1'b0;
    pst = 0; dst = 0; opt = 0;
    #2;
    compare(tag);
    addr = CA; #1;
    chk({tag, " ctrl"}, rdata, 8'h00);
    @(negedge clk);
    rst_ni = 1'b1; #1;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset("R1 reset");
    wr(PK, 8'h56, "R2 first");
    wr(PK, 8'hAE, "R2 open");
    wr(PK, 8'h11, "R8 junk while open");
    wr(PK, 8'h56, "R8 key while open");
    wr(SA, 8'h00, "R6 relock prog");
    wr(SA, 8'hFF, "R6 write ones");
    wr(PK, 8'h56, "R8 no lockout a");
    wr(PK, 8'hAE, "R8 no lockout b");
    wr(SA, 8'h00, "R6 relock again");
    wr(PK, 8'h56, "R10 prog half");
    wr(DK, 8'hAE, "R3 first");
    wr(DK, 8'h56, "R3 open");
    wr(PK, 8'hAE, "R10 prog completes");
    wr(CA, 8'h80, "R7 opt on");
    addr = CA; #1; chk("R7 ctrl readback", rdata, 8'h80);
    wr(SA, 8'h02, "R6 relock data only");
    wr(DK, 8'hAE, "R7 reopen a");
    wr(DK, 8'h56, "R7 reopen b");
    wr(CA, 8'h00, "R7 opt off");
    wr(SA, 8'h02, "R6 relock data");
    wr(DK, 8'h12, "R5 wrong first");
    wr(DK, 8'hAE, "R5 retry a");
    wr(DK, 8'h56, "R5 retry b");
    wr(SA, 8'h02, "R5 relock");
    wr(DK, 8'hAE, "R5 first");
    wr(DK, 8'h33, "R5 wrong second");
    wr(DK, 8'hAE, "R5 again a");
    wr(DK, 8'h56, "R5 again b");
    wr(SA, 8'h02, "R5 relock2");
    wr(DK, 8'hAE, "R5 double a");
    wr(DK, 8'hAE, "R5 double b");
    wr(DK, 8'h56, "R5 double c");
    wr(SA, 8'h00, "R6 relock both");
    wr(PK, 8'hAE, "R4 reversed first");
    wr(PK, 8'h56, "R4 reversed second");
    wr(PK, 8'h56, "R4 ignored a");
    wr(PK, 8'hAE, "R4 ignored b");
    wr(DK, 8'hAE, "R10 data ok a");
    wr(DK, 8'h56, "R10 data ok b");
    do_reset("R9 reset");
    wr(PK, 8'h56, "R9 unlock a");
    wr(PK, 8'hAE, "R9 unlock b");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule